// File: doc/BRIEF.md
# Bus turnaround idle-cycle inserter

This block sits between the requesters of an external memory bus and the state machine that runs bus accesses. It keeps a record of the address area and the direction of the last access that finished. When a new access is requested and the bus could suffer a data collision, it holds the request off for a programmed number of idle cycles before granting it. A collision is possible when the new access targets a different area than the previous one, or when a read is followed by a write. Consecutive writes, reads to the same area, and a write followed by a read to the same area go through without a pause.

Each of the seven areas has a 2-bit idle-cycle setting. The setting that applies is the one for the area of the previous access. Empty cycles that the bus has already spent since the previous access ended count towards the programmed idle time. A bus arbitration event clears the requirement, because handing the bus over already leaves empty cycles on it.

Requests use a valid/ready handshake. A request is granted in the cycle where `req_valid` and `req_ready` are both high. Once `req_valid` is raised it stays high, and its area and direction stay unchanged, until that grant. The block drives `req_ready` low while a granted access is still running, which means from the grant until the cycle in which the bus state machine pulses `acc_done`, and while turnaround idle cycles are still owed.

Top module: `bus_turnaround_gate`

## Requirements
- R1: The area number and the direction of an access are latched at its grant. They become the stored previous-access state in the cycle after that access's `acc_done` pulse.
- R2: When the requested area differs from the stored area, the request waits for the idle count of the stored area. The requested area's own count does not apply.
- R3: A write that follows a read in the same area waits for that area's idle count.
- R4: Read after read, write after write and write after read within the same area are granted with no idle cycles.
- R5: The idle count of area i is `idle_cfg[2*i+1:2*i]`, read as 0 to 3 cycles. A count of 0 disables insertion after accesses to that area.
- R6: Each empty cycle since the previous `acc_done` reduces the owed idle cycles by one, and the result never goes below zero. The empty-cycle count saturates at 3, so long gaps do not wrap around. The request is granted in the cycle after the last owed idle cycle.
- R7: An `arb_evt` pulse invalidates the stored previous-access state, so the next request owes no idle cycles. If `arb_evt` and `acc_done` arrive together, the invalidation wins.
- R8: After reset the previous-access state is invalid. `req_ready` is high and `idle_ins` is low, and the first request is granted at once.
- R9: `req_ready` is low from a grant up to and including the cycle of `acc_done`. `idle_ins` is high exactly while a valid request is held back only by owed idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_cfg | input | 14 | Idle-cycle counts, 2 bits per area, area i at bits 2i+1:2i |
| req_valid | input | 1 | Access request pending |
| req_area | input | 3 | Area of the requested access (0 to 6) |
| req_write | input | 1 | Direction of the requested access, 1 = write, 0 = read |
| req_ready | output | 1 | Grant; the access starts when this and req_valid are both high |
| acc_done | input | 1 | One-cycle pulse in the last cycle of the running access |
| arb_evt | input | 1 | One-cycle pulse when the bus is handed over by arbitration |
| idle_ins | output | 1 | A pending request is being held for turnaround idle cycles |

## Verification
On every cycle the assertions check the handshake rules. They confirm that a held request keeps its area and direction, that `acc_done` only arrives while an access runs, and that the empty-cycle counter steps up by one until it saturates. They also check that same-area writes after writes never owe idle cycles, that an arbitration pulse invalidates the history, and that nothing is owed with no valid history. Only the bench's scenarios can show the exact number of idle cycles for each transition kind. The same goes for the use of the previous area's field rather than the new one, the subtraction of a chosen gap, and saturation over a gap longer than the counter's range.

// File: rtl/tat_pkg.sv
package tat_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;

  localparam int TAT_AREA_W = 3;
  localparam int TAT_NUM_AREAS = 7;
  localparam int TAT_IDLE_W = 2;
endpackage

// File: rtl/tat_history.sv
module tat_history #(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic [AREA_W-1:0] grant_area,
  input  tat_pkg::dir_e     grant_dir,
  input  logic              done,
  input  logic              arb,
  output logic              busy,
  output logic              prev_valid,
  output logic [AREA_W-1:0] prev_area,
  output tat_pkg::dir_e     prev_dir
);
  import tat_pkg::*;

  logic [AREA_W-1:0] cur_area;
  dir_e              cur_dir;

  // tracks the access in progress and its attributes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_area <= '0;
      cur_dir  <= DIR_RD;
    end else if (grant) begin
      busy     <= 1'b1;
      cur_area <= grant_area;
      cur_dir  <= grant_dir;
    end else if (done) begin
      busy     <= 1'b0;
    end
  end

  // previous-access record; arbitration wins over completion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_area  <= '0;
      prev_dir   <= DIR_RD;
    end else if (arb) begin
      prev_valid <= 1'b0;
    end else if (done) begin
      prev_valid <= 1'b1;
      prev_area  <= cur_area;
      prev_dir   <= cur_dir;
    end
  end

  // R7: an arbitration pulse leaves no valid history behind
  a_r7_arb_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arb |=> !prev_valid);

  // R1: completion of an access makes the history valid
  a_r1_done_records: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arb) |=> prev_valid);
endmodule

// File: rtl/tat_gap_counter.sv
module tat_gap_counter #(
  parameter int IDLE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hold,
  output logic [IDLE_W-1:0] gap
);
  localparam logic [IDLE_W-1:0] GAP_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)             gap <= GAP_MAX;
    else if (clear)         gap <= '0;
    else if (!hold && gap != GAP_MAX) gap <= gap + 1'b1;
  end

  // R6: each empty cycle adds one until saturation
  a_r6_gap_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !hold && gap != GAP_MAX) |=> gap == $past(gap) + 1'b1);

  a_r6_gap_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && gap == GAP_MAX) |=> gap == GAP_MAX);
endmodule

// File: rtl/tat_need.sv
module tat_need #(
  parameter int AREA_W    = 3,
  parameter int NUM_AREAS = 7,
  parameter int IDLE_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_AREAS*IDLE_W-1:0] cfg,
  input  logic                        prev_valid,
  input  logic [AREA_W-1:0]           prev_area,
  input  tat_pkg::dir_e               prev_dir,
  input  logic [AREA_W-1:0]           req_area,
  input  tat_pkg::dir_e               req_dir,
  output logic [IDLE_W-1:0]           need
);
  import tat_pkg::*;

  localparam int AREA_SLOTS = 1 << AREA_W;

  logic [IDLE_W-1:0] fld [AREA_SLOTS];

  // unpack per-area fields; unused slots read as zero
  for (genvar i = 0; i < AREA_SLOTS; i++) begin : g_fld
    if (i < NUM_AREAS) begin : g_used
      assign fld[i] = cfg[i*IDLE_W +: IDLE_W];
    end else begin : g_spare
      assign fld[i] = '0;
    end
  end

  logic area_change;
  logic rd_to_wr;

  always_comb begin
    area_change = (req_area != prev_area);
    rd_to_wr    = (prev_dir == DIR_RD) && (req_dir == DIR_WR);
    if (prev_valid && (area_change || rd_to_wr)) need = fld[prev_area];
    else                                         need = '0;
  end

  // R4: a same-area write after a write never owes idle cycles
  a_r4_wr_wr_free: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_dir == DIR_WR && req_dir == DIR_WR && req_area == prev_area) |-> need == '0);

  // R8: no history, nothing owed
  a_r8_invalid_free: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_valid |-> need == '0);
endmodule

// File: rtl/bus_turnaround_gate.sv
module bus_turnaround_gate #(
  parameter int AREA_W    = tat_pkg::TAT_AREA_W,
  parameter int NUM_AREAS = tat_pkg::TAT_NUM_AREAS,
  parameter int IDLE_W    = tat_pkg::TAT_IDLE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_AREAS*IDLE_W-1:0] idle_cfg,
  input  logic                        req_valid,
  input  logic [AREA_W-1:0]           req_area,
  input  logic                        req_write,
  output logic                        req_ready,
  input  logic                        acc_done,
  input  logic                        arb_evt,
  output logic                        idle_ins
);
  import tat_pkg::*;

  localparam logic [IDLE_W-1:0] GAP_MAX = '1;

  logic              busy;
  logic              prev_valid;
  logic [AREA_W-1:0] prev_area;
  dir_e              prev_dir;
  dir_e              req_dir;
  logic [IDLE_W-1:0] gap;
  logic [IDLE_W-1:0] need;
  logic              gap_ok;
  logic              grant;

  assign req_dir   = req_write ? DIR_WR : DIR_RD;
  assign gap_ok    = (gap >= need);
  assign req_ready = !busy && gap_ok;
  assign grant     = req_valid && req_ready;
  assign idle_ins  = req_valid && !busy && !gap_ok;

  tat_history #(.AREA_W(AREA_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .grant_area (req_area),
    .grant_dir  (req_dir),
    .done       (acc_done),
    .arb        (arb_evt),
    .busy       (busy),
    .prev_valid (prev_valid),
    .prev_area  (prev_area),
    .prev_dir   (prev_dir)
  );

  tat_gap_counter #(.IDLE_W(IDLE_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (acc_done),
    .hold  (busy),
    .gap   (gap)
  );

  tat_need #(.AREA_W(AREA_W), .NUM_AREAS(NUM_AREAS), .IDLE_W(IDLE_W)) u_need (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (idle_cfg),
    .prev_valid (prev_valid),
    .prev_area  (prev_area),
    .prev_dir   (prev_dir),
    .req_area   (req_area),
    .req_dir    (req_dir),
    .need       (need)
  );

  // R9: a held request keeps its attributes
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_area) && $stable(req_write)));

  // R9: completion only while an access runs
  a_r9_done_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> busy);

  // R9: after a grant the bus is busy
  a_r9_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !req_ready);

  // R6: a held request means the empty-cycle count is below saturation
  a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ins |-> gap != GAP_MAX);

  // R8: without history an idle bus grants at once
  a_r8_first_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_valid && !busy) |-> req_ready);
endmodule

// File: tb/tb_bus_turnaround_gate.sv
module tb_bus_turnaround_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] idle_cfg;
  logic        req_valid = 1'b0;
  logic [2:0]  req_area = '0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic        acc_done = 1'b0;
  logic        arb_evt = 1'b0;
  logic        idle_ins;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  // area6..area0 = 2,1,3,0,3,2,1
  assign idle_cfg = {2'd2, 2'd1, 2'd3, 2'd0, 2'd3, 2'd2, 2'd1};

  bus_turnaround_gate dut (
    .clk(clk), .rst_n(rst_n), .idle_cfg(idle_cfg),
    .req_valid(req_valid), .req_area(req_area), .req_write(req_write),
    .req_ready(req_ready), .acc_done(acc_done), .arb_evt(arb_evt),
    .idle_ins(idle_ins)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one access: wait gap empty cycles, request, count held cycles, complete
  task automatic run_access(input int area, input bit wr, input int gap,
                            input int exp_wait, input string req);
    int waits = 0;
    int idle_miss = 0;
    repeat (gap) @(negedge clk);
    req_valid = 1'b1;
    req_area  = 3'(area);
    req_write = wr;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (req_ready) break;
      if (!idle_ins) idle_miss++;
      waits++;
      @(negedge clk);
    end
    check(req, waits, exp_wait);
    check("R9 idle_ins while held", idle_miss, 0);
    @(negedge clk);
    req_valid = 1'b0;
    acc_done  = 1'b1;
    #1;
    check("R9 ready low while busy", int'(req_ready), 0);
    @(negedge clk);
    acc_done = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R8 ready after reset", int'(req_ready), 1);
    check("R8 idle_ins after reset", int'(idle_ins), 0);
  endtask

  task automatic t_first();
    run_access(2, 1'b0, 0, 0, "R8 first access");
  endtask

  task automatic t_same_area_dirs();
    run_access(2, 1'b0, 0, 0, "R4 read after read");
    run_access(2, 1'b1, 0, 3, "R3 write after read");
    run_access(2, 1'b1, 0, 0, "R4 write after write");
    run_access(2, 1'b0, 0, 0, "R4 read after write");
  endtask

  task automatic t_area_change();
    run_access(1, 1'b0, 0, 3, "R2 R5 uses previous area field");
    run_access(3, 1'b0, 0, 2, "R2 R1 area 1 field");
    run_access(4, 1'b1, 0, 0, "R5 zero field disables");
  endtask

  task automatic t_gap();
    run_access(0, 1'b0, 1, 2, "R6 gap of one subtracted");
    run_access(4, 1'b0, 0, 1, "R2 area 0 field");
    run_access(6, 1'b1, 5, 0, "R6 long gap saturates");
  endtask

  task automatic t_arb();
    arb_evt = 1'b1;
    @(negedge clk);
    arb_evt = 1'b0;
    run_access(1, 1'b0, 0, 0, "R7 arbitration clears history");
    #1;
    check("R9 idle_ins low when no request", int'(idle_ins), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_same_area_dirs();
    t_area_change();
    t_gap();
    t_arb();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 5000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule